// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synthesizable slave on a two-wire serial bus that fronts a 256 x 8 memory array held in on-chip flops. Bytes are grouped in 32 pages of 8. Both bus lines are sampled on a fast system clock through two-flop synchronisers, and SDA is driven as an open-drain enable. When `sda_oe` is high, the chip pad pulls the line low.

A master opens each transfer with a start condition and an address byte. That byte carries a fixed family code, three strap bits and a direction bit. After that the slave serves byte and page writes, and it serves reads from a persistent address counter. These reads can be current-address, random (a dummy write followed by a repeated start) or sequential. When a write sequence that stored data is closed by a stop, a programmable busy timer runs. For that whole window the slave ignores the bus, so a master can poll with address bytes until it sees an acknowledge. A write-protect input makes the whole array read-only.

Top module: `eeprom_2w_slave`

## Requirements
- R1: After reset `sda_oe` is 0, every array byte reads 0x00, and the address counter holds 0.
- R2: The first byte after a start is acknowledged (SDA low during the ninth SCL high) only when its bits 7..4 equal 1010 and bits 3..1 equal `strap_i[2:0]`. Otherwise it is not acknowledged, and later bytes are ignored until the next start.
- R3: For a write (address byte bit 0 = 0), the second byte is a word address and the following bytes are data. Each byte is acknowledged, and each data byte is stored at the current word address.
- R4: In a write, after each data byte only address bits 2..0 increment, with wrap from 7 to 0, while bits 7..3 stay fixed. A ninth data byte therefore overwrites the first one written.
- R5: A stop that closes a write which stored at least one byte starts a busy window of `BUSY_CLKS` system clocks. During that window no address byte of either direction is acknowledged. Once the window ends, address bytes are acknowledged again.
- R6: For a read (address byte bit 0 = 1), the slave sends the byte at the address counter and then advances the counter by one. After a write, the counter points one past the last written location within its page.
- R7: A random read works as follows. A write-addressed byte plus a word address, followed by a repeated start and a read-addressed byte, returns the byte at that word address.
- R8: While the master acknowledges, a read continues with the next address, and it wraps from 255 to 0. A master non-acknowledge ends the read, and `sda_oe` stays 0 until the next start.
- R9: While `wp_i` is 1, data bytes are acknowledged but not stored, and the closing stop starts no busy window.
- R10: Read data leaves MSB first. `sda_oe` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| strap_i | input | 3 | Hard-wired device address bits |
| wp_i | input | 1 | Write protect, 1 = array read-only |
| sda_oe | output | 1 | 1 = pull SDA low |

## Verification
A wrong bit counter or state shows as a missing or misplaced acknowledge, at the ninth SCL pulse of the very byte where it goes astray. A wrong address counter shows only at the next read: it returns the wrong byte, and that byte may come several transfers later. For this reason the bench reads back after every write. It also mixes current-address reads into the random traffic, so that counter drift is caught quickly. A stuck busy timer shows as a poll that never succeeds. A timer that ends early shows as an acknowledge on the first poll that follows a write.

// File: rtl/eeprom_2w_slave.sv
module eeprom_2w_slave #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3,
  parameter int BUSY_CLKS = 1000,
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BW = $clog2(BUSY_CLKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WADDR, S_WDATA, S_RD} st_t;

  logic [2:0] scl_s, sda_s;
  logic scl_r, scl_p, sda_r, sda_p;
  logic start_c, stop_c, rise_c, fall_c;
  st_t state;
  logic [3:0] bitc;
  logic [7:0] shreg, tx;
  logic rw, pend;
  logic [ADDR_W-1:0] addr;
  logic [BW-1:0] busy_cnt;
  logic [7:0] mem [DEPTH];
  logic busy, dev_hit;

  assign scl_r = scl_s[1];
  assign scl_p = scl_s[2];
  assign sda_r = sda_s[1];
  assign sda_p = sda_s[2];
  assign start_c = scl_r & scl_p & sda_p & ~sda_r;
  assign stop_c = scl_r & scl_p & ~sda_p & sda_r;
  assign rise_c = scl_r & ~scl_p;
  assign fall_c = ~scl_r & scl_p;
  assign busy = busy_cnt != '0;
  assign dev_hit = shreg[7:1] == {DEV_ID, strap_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 3'b111;
      sda_s <= 3'b111;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      bitc <= '0;
      shreg <= '0;
      tx <= '0;
      rw <= 1'b0;
      pend <= 1'b0;
      addr <= '0;
      busy_cnt <= '0;
      sda_oe <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (busy) busy_cnt <= busy_cnt - BW'(1);
      if (stop_c) begin
        state <= S_IDLE;
        sda_oe <= 1'b0;
        pend <= 1'b0;
        if (pend && !busy) busy_cnt <= BW'(BUSY_CLKS);
      end else if (start_c) begin
        sda_oe <= 1'b0;
        bitc <= '0;
        state <= busy ? S_IDLE : S_DEV;
      end else if (rise_c) begin
        case (state)
          S_DEV, S_WADDR, S_WDATA: begin
            if (bitc < 4'd8) begin
              shreg <= {shreg[6:0], sda_r};
              bitc <= bitc + 4'd1;
            end else if (bitc == 4'd8) bitc <= 4'd9;
          end
          S_RD: begin
            if (bitc < 4'd8) bitc <= bitc + 4'd1;
            else if (bitc == 4'd8) begin
              if (sda_r) state <= S_IDLE;
              else bitc <= 4'd9;
            end
          end
          default: ;
        endcase
      end else if (fall_c) begin
        case (state)
          S_DEV: begin
            if (bitc == 4'd8) begin
              if (dev_hit) begin
                sda_oe <= 1'b1;
                rw <= shreg[0];
              end else state <= S_IDLE;
            end else if (bitc == 4'd9) begin
              bitc <= '0;
              if (rw) begin
                state <= S_RD;
                tx <= mem[addr];
                sda_oe <= ~mem[addr][7];
                addr <= addr + 1'b1;
              end else begin
                state <= S_WADDR;
                sda_oe <= 1'b0;
              end
            end
          end
          S_WADDR: begin
            if (bitc == 4'd8) begin
              sda_oe <= 1'b1;
              addr <= shreg[ADDR_W-1:0];
            end else if (bitc == 4'd9) begin
              sda_oe <= 1'b0;
              bitc <= '0;
              state <= S_WDATA;
            end
          end
          S_WDATA: begin
            if (bitc == 4'd8) begin
              sda_oe <= 1'b1;
              if (!wp_i) begin
                mem[addr] <= shreg;
                pend <= 1'b1;
              end
              addr <= {addr[ADDR_W-1:PAGE_W], PAGE_W'(addr[PAGE_W-1:0] + 1'b1)};
            end else if (bitc == 4'd9) begin
              sda_oe <= 1'b0;
              bitc <= '0;
            end
          end
          S_RD: begin
            if (bitc >= 4'd1 && bitc <= 4'd7) begin
              tx <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[6];
            end else if (bitc == 4'd8) sda_oe <= 1'b0;
            else if (bitc == 4'd9) begin
              bitc <= '0;
              tx <= mem[addr];
              sda_oe <= ~mem[addr][7];
              addr <= addr + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eeprom_2w_slave_chk.sv
module eeprom_2w_slave_chk #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3,
  parameter int BW = 10,
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_r,
  input logic              scl_p,
  input logic              sda_oe,
  input logic [BW-1:0]     busy_cnt,
  input logic [2:0]        state,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        shreg,
  input logic [2:0]        strap_i
);
  localparam logic [2:0] ST_DEV = 3'd1;
  localparam logic [2:0] ST_WDATA = 3'd3;

  a_r2_ack_only_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEV && $rose(sda_oe)) |-> shreg[7:1] == {DEV_ID, strap_i});

  a_r4_page_row_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WDATA && $past(state) == ST_WDATA)
      |-> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));

  a_r5_silent_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cnt != '0) |-> !sda_oe);

  a_r5_busy_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cnt != '0) |=> busy_cnt == $past(busy_cnt) - BW'(1));

  a_r10_oe_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_r && scl_p) |=> $stable(sda_oe));
endmodule

bind eeprom_2w_slave eeprom_2w_slave_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BW(BW), .DEV_ID(DEV_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_r(scl_r), .scl_p(scl_p), .sda_oe(sda_oe),
  .busy_cnt(busy_cnt), .state(state), .addr(addr), .shreg(shreg), .strap_i(strap_i)
);

// File: tb/test_eeprom_2w_slave.sv
module test_eeprom_2w_slave;
  localparam int Q = 5;
  localparam int BUSY = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic oe;
  logic sda_line;

  assign sda_line = m_sda & ~oe;

  always #5 clk = ~clk;

  eeprom_2w_slave #(.BUSY_CLKS(BUSY)) i_eeprom_2w_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .strap_i(strap), .wp_i(wp), .sda_oe(oe)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] ref_mem [256];
  logic [7:0] ref_ptr = 8'h00;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  function automatic logic [7:0] dev(input logic r);
    return {4'b1010, strap, r};
  endfunction

  function automatic logic [7:0] pg_next(input logic [7:0] a);
    return {a[7:3], a[2:0] + 3'd1};
  endfunction

  task automatic start_c();
    m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0; q();
  endtask

  task automatic stop_c();
    m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q();
    end
    m_sda = 1'b1; q(); m_scl = 1'b1; q();
    ack = (sda_line == 1'b0);
    q(); m_scl = 1'b0; q();
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; q(); m_scl = 1'b1; q();
      b[i] = sda_line;
      q(); m_scl = 1'b0; q();
    end
    m_sda = nack; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q();
  endtask

  task automatic poll(output int nacks);
    bit ack;
    nacks = 0;
    for (int k = 0; k < 40; k++) begin
      start_c(); send_byte(dev(1'b0), ack); stop_c();
      if (ack) break;
      nacks++;
    end
  endtask

  task automatic write_seq(input logic [7:0] wa, input int n, input bit do_stop);
    bit ack;
    start_c();
    send_byte(dev(1'b0), ack); chk("R2 write address ack", ack, 1);
    send_byte(wa, ack); chk("R3 word address ack", ack, 1);
    ref_ptr = wa;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      send_byte(d, ack); chk("R3 data ack", ack, 1);
      if (!wp) ref_mem[ref_ptr] = d;
      ref_ptr = pg_next(ref_ptr);
    end
    if (do_stop) stop_c();
  endtask

  task automatic read_seq(input bit rnd, input logic [7:0] a, input int n);
    bit ack;
    logic [7:0] d;
    if (rnd) write_seq(a, 0, 1'b0);
    start_c();
    send_byte(dev(1'b1), ack); chk("R6 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, d);
      chk(rnd ? "R7 R8 R10 random read data" : "R6 R8 R10 current read data",
          d, ref_mem[ref_ptr]);
      ref_ptr = ref_ptr + 8'd1;
    end
    q();
    chk("R8 released after master nack", oe, 0);
    stop_c();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int nacks;
    bit ack;
    void'($urandom(32'h2c0ffee5));
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    q();
    chk("R1 sda released after reset", oe, 0);
    read_seq(1'b0, 8'h00, 3);

    write_seq(8'h42, 1, 1'b1);
    start_c(); send_byte(dev(1'b1), ack); stop_c();
    chk("R5 read address ignored while busy", ack, 0);
    poll(nacks);
    chk("R5 poll saw busy first", nacks > 0, 1);
    chk("R5 busy window ends", nacks < 6, 1);
    read_seq(1'b1, 8'h42, 1);

    write_seq(8'h1D, 10, 1'b1);
    poll(nacks);
    chk("R5 page write busy", nacks > 0, 1);
    read_seq(1'b1, 8'h18, 8);
    write_seq(8'h35, 2, 1'b1);
    poll(nacks);
    read_seq(1'b0, 8'h00, 2);

    read_seq(1'b1, 8'hFD, 5);

    start_c();
    send_byte({4'b1010, 3'b100, 1'b0}, ack); chk("R2 strap mismatch nack", ack, 0);
    send_byte(8'h10, ack); chk("R2 ignored until next start", ack, 0);
    stop_c();
    start_c();
    send_byte({4'b1011, strap, 1'b1}, ack); chk("R2 family mismatch nack", ack, 0);
    stop_c();
    read_seq(1'b0, 8'h00, 1);

    wp = 1'b1;
    write_seq(8'h60, 3, 1'b1);
    poll(nacks);
    chk("R9 no busy under write protect", nacks, 0);
    wp = 1'b0;
    read_seq(1'b1, 8'h60, 3);

    for (int it = 0; it < 14; it++) begin
      int op;
      op = int'($urandom % 3);
      if (op == 0) begin
        write_seq(8'($urandom), 1 + int'($urandom % 10), 1'b1);
        poll(nacks);
        chk("R5 random write busy", nacks > 0, 1);
      end else if (op == 1) read_seq(1'b1, 8'($urandom), 1 + int'($urandom % 6));
      else read_seq(1'b0, 8'h00, 1 + int'($urandom % 4));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule